// File: doc/BRIEF.md
# Bus-Activity Watchdog Timer

This block supervises a host processor by watching the two lines of a serial bus. The host proves it is alive by putting a start condition on the bus and closing it, at any later point, with a stop condition. Each such start-then-stop pair restarts a time-out counter that advances on an external timebase tick. If the counter reaches the selected period first, the block issues a single-cycle expiry pulse to the reset generator. The reset generator then drives the reset output, which is not part of this block.

The period comes from a 2-bit setting held by the control-register block. Three codes select a long, a medium or a short period. The fourth code switches the watchdog off, and that code is also the power-up value. The three period lengths are parameters counted in ticks, so an integration can map them to real time and a bench can shrink them. The bus lines arrive asynchronously. Each line passes through a synchroniser before edge detection. While the chip-level reset is active, the reset generator drives a hold input, and that input keeps the counter and the pending-start flag cleared.

Top module: `bus_wdog`

## Requirements
- R1: While `rst_n` is low, `expire_o` is 0 and the stored setting takes the disabled code 2'b11. Ticks given during reset produce no pulse.
- R2: An expiry is signalled as `expire_o` high for exactly one clock cycle.
- R3: The setting on `period_sel_i` selects the period: 2'b00 gives P_LONG ticks, 2'b01 gives P_MID ticks and 2'b10 gives P_SHORT ticks. The pulse appears on the clock after the tick that completes the period, and counting then starts again from zero, so expiries repeat with that period.
- R4: With setting 2'b11, no expiry pulse is produced, including when the watchdog is switched off part-way through a count.
- R5: A start condition (SDA falling while SCL is high) followed later by a stop condition (SDA rising while SCL is high) restarts the count from zero. The stop may come after ticks have elapsed.
- R6: A start condition with no following stop does not restart the count.
- R7: A stop condition with no pending start does not restart the count. SDA edges while SCL is low are neither a start nor a stop.
- R8: Any change of `period_sel_i` restarts the count from zero.
- R9: While `hold_i` is high, the count and the pending-start flag are cleared and no pulse is produced. A start seen during hold therefore cannot pair with a stop after hold ends.
- R10: When a restart and the period-completing tick act on the same clock edge, the restart wins: no pulse is produced and the count starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_i | input | 1 | High while the chip reset is active; clears the count and the pending start |
| tick_i | input | 1 | One-cycle timebase tick that advances the count |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line, asynchronous |
| period_sel_i | input | 2 | Period setting: 00 long, 01 medium, 10 short, 11 off |
| expire_o | output | 1 | One-cycle pulse when the period elapses without a restart |

## Verification
Two events can land on the same clock edge: a restart formed by a stop that closes a pending start, and the tick that completes the period. The bench counts the counter up to one tick short of the period and then raises SDA with SCL high. It drives the tick exactly two clock edges later, which is the edge on which the synchronised stop becomes visible, so that both act at once. The bench judges the outcome by requiring zero pulses in that window and then a full fresh period before the next pulse. A separate check covers a setting change in the middle of a count, which must also restart the count.

// File: rtl/bwd_pkg.sv
package bwd_pkg;

  typedef logic [1:0] wd_sel_t;

  localparam wd_sel_t SEL_LONG  = 2'b00;
  localparam wd_sel_t SEL_MID   = 2'b01;
  localparam wd_sel_t SEL_SHORT = 2'b10;
  localparam wd_sel_t SEL_OFF   = 2'b11;

  // Period length in ticks for a setting; zero means the watchdog is off.
  function automatic int unsigned period_len(wd_sel_t sel, int unsigned len_long,
                                             int unsigned len_mid, int unsigned len_short);
    case (sel)
      SEL_LONG:  return len_long;
      SEL_MID:   return len_mid;
      SEL_SHORT: return len_short;
      default:   return 0;
    endcase
  endfunction

  // Bus start: data falls while the clock line is high in both samples.
  function automatic logic is_start(logic scl_now, logic scl_prev, logic sda_now, logic sda_prev);
    return scl_now & scl_prev & sda_prev & ~sda_now;
  endfunction

  // Bus stop: data rises while the clock line is high in both samples.
  function automatic logic is_stop(logic scl_now, logic scl_prev, logic sda_now, logic sda_prev);
    return scl_now & scl_prev & ~sda_prev & sda_now;
  endfunction

endpackage

// File: rtl/bwd_sync.sv
module bwd_sync #(
  parameter int STAGES = 2,
  parameter int W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '1;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/bwd_cond_detect.sv
module bwd_cond_detect
  import bwd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic start_o,
  output logic stop_o
);
  logic scl_prev_q, sda_prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_prev_q <= scl_s_i;
      sda_prev_q <= sda_s_i;
    end
  end

  assign start_o = is_start(scl_s_i, scl_prev_q, sda_s_i, sda_prev_q);
  assign stop_o  = is_stop(scl_s_i, scl_prev_q, sda_s_i, sda_prev_q);
endmodule

// File: rtl/bwd_kick_seq.sv
module bwd_kick_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic start_i,
  input  logic stop_i,
  output logic kick_o,
  output logic pend_o
);
  logic pend_q;

  // A stop counts as a restart only when a start is waiting for it.
  assign kick_o = stop_i & pend_q & ~hold_i;
  assign pend_o = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (hold_i)  pend_q <= 1'b0;
    else if (start_i) pend_q <= 1'b1;
    else if (stop_i)  pend_q <= 1'b0;
  end
endmodule

// File: rtl/bwd_counter.sv
module bwd_counter
  import bwd_pkg::*;
#(
  parameter int unsigned P_LONG  = 1400,
  parameter int unsigned P_MID   = 600,
  parameter int unsigned P_SHORT = 200,
  parameter int          CW      = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_i,
  input  logic          tick_i,
  input  logic          kick_i,
  input  wd_sel_t       sel_i,
  output logic          expire_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] limit_o,
  output wd_sel_t       sel_q_o
);
  wd_sel_t       sel_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] limit;
  logic          sel_chg, off, at_end, clear;

  assign limit   = CW'(period_len(sel_q, P_LONG, P_MID, P_SHORT));
  assign sel_chg = (sel_i != sel_q);
  assign off     = (sel_q == SEL_OFF);
  assign at_end  = (cnt_q == limit - 1'b1);
  assign clear   = hold_i | kick_i | sel_chg | off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= SEL_OFF;
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      sel_q    <= sel_i;
      expire_o <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (at_end) begin
          cnt_q    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign cnt_o   = cnt_q;
  assign limit_o = limit;
  assign sel_q_o = sel_q;
endmodule

// File: rtl/bus_wdog.sv
module bus_wdog
  import bwd_pkg::*;
#(
  parameter int unsigned P_LONG      = 1400,
  parameter int unsigned P_MID       = 600,
  parameter int unsigned P_SHORT     = 200,
  parameter int          SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_i,
  input  logic       tick_i,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] period_sel_i,
  output logic       expire_o
);
  localparam int CW = $clog2(P_LONG + 1);

  logic [1:0]    lines_s;
  logic          scl_s, sda_s;
  logic          start_ev, stop_ev, kick_ev, pend;
  logic [CW-1:0] cnt, limit;
  wd_sel_t       sel_q;

  bwd_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  bwd_cond_detect u_cond (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_s_i (scl_s),
    .sda_s_i (sda_s),
    .start_o (start_ev),
    .stop_o  (stop_ev)
  );

  bwd_kick_seq u_kick (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold_i),
    .start_i (start_ev),
    .stop_i  (stop_ev),
    .kick_o  (kick_ev),
    .pend_o  (pend)
  );

  bwd_counter #(.P_LONG(P_LONG), .P_MID(P_MID), .P_SHORT(P_SHORT), .CW(CW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .hold_i   (hold_i),
    .tick_i   (tick_i),
    .kick_i   (kick_ev),
    .sel_i    (period_sel_i),
    .expire_o (expire_o),
    .cnt_o    (cnt),
    .limit_o  (limit),
    .sel_q_o  (sel_q)
  );
endmodule

// File: rtl/bwd_checker.sv
module bwd_checker #(
  parameter int CW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold_i,
  input logic          tick_i,
  input logic [1:0]    period_sel_i,
  input logic          expire_o,
  input logic          kick_ev,
  input logic          pend,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] limit,
  input logic [1:0]    sel_q
);
  assert_one_cycle_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  assert_expire_on_last_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> ($past(tick_i) && ($past(cnt) == $past(limit) - 1'b1)));

  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != 2'b11) |-> (cnt < limit));

  assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(period_sel_i) == 2'b11) |-> !expire_o);

  // Covers R10 too: a restart beats a coinciding final tick.
  assert_kick_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ev |=> ((cnt == '0) && !expire_o));

  assert_setting_change_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (period_sel_i != sel_q) |=> (cnt == '0));

  assert_hold_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> ((cnt == '0) && !pend && !expire_o));
endmodule

bind bus_wdog bwd_checker #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .hold_i       (hold_i),
  .tick_i       (tick_i),
  .period_sel_i (period_sel_i),
  .expire_o     (expire_o),
  .kick_ev      (kick_ev),
  .pend         (pend),
  .cnt          (cnt),
  .limit        (limit),
  .sel_q        (sel_q)
);

// File: tb/bus_wdog_tb.sv
`timescale 1ns/1ps
module bus_wdog_tb;
  localparam int unsigned T_LONG  = 10;
  localparam int unsigned T_MID   = 6;
  localparam int unsigned T_SHORT = 3;

  logic       clk = 1'b0;
  logic       rst_n, hold, tick, scl, sda;
  logic [1:0] psel;
  logic       expire;

  always #10 clk = ~clk;  // 50 MHz

  bus_wdog #(.P_LONG(T_LONG), .P_MID(T_MID), .P_SHORT(T_SHORT), .SYNC_STAGES(2)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .hold_i       (hold),
    .tick_i       (tick),
    .scl_i        (scl),
    .sda_i        (sda),
    .period_sel_i (psel),
    .expire_o     (expire)
  );

  typedef struct {
    string tag;
    int    exp_pulses;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  int    seen  = 0;
  bit    done  = 0;

  // Monitor: counts expiry pulses and compares at each queued item.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expire === 1'b1) seen++;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_vec++;
        if (seen != it.exp_pulses) begin
          n_bad++;
          $display("FAIL %s: pulses=%0d expected=%0d", it.tag, seen, it.exp_pulses);
        end
        seen = 0;
      end
    end
  end

  task automatic w3();
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_n(input string tag, input int n);
    item_t it;
    repeat (2) @(negedge clk);
    it.tag = tag;
    it.exp_pulses = n;
    q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_sel(input logic [1:0] v);
    @(negedge clk); psel = v;
    w3();
  endtask

  task automatic bus_start();
    @(negedge clk); scl = 1'b1; sda = 1'b1; w3();
    sda = 1'b0; w3();
    scl = 1'b0; w3();
  endtask

  task automatic bus_stop();
    @(negedge clk); scl = 1'b0; sda = 1'b0; w3();
    scl = 1'b1; w3();
    sda = 1'b1; w3();
  endtask

  task automatic restart();
    bus_start();
    bus_stop();
  endtask

  initial begin
    rst_n = 1'b0; hold = 1'b0; tick = 1'b0; scl = 1'b1; sda = 1'b1; psel = 2'b11;
    ticks(3);
    expect_n("R1 no pulse in reset", 0);
    @(negedge clk); rst_n = 1'b1;

    ticks(20);
    expect_n("R4 default off", 0);

    set_sel(2'b10);
    ticks(2);
    expect_n("R3 short before end", 0);
    ticks(1);
    expect_n("R3 short expiry", 1);
    ticks(6);
    expect_n("R2 R3 short repeats", 2);

    set_sel(2'b01);
    ticks(5);
    expect_n("R3 mid before end", 0);
    ticks(1);
    expect_n("R3 mid expiry", 1);

    set_sel(2'b00);
    ticks(9);
    expect_n("R3 long before end", 0);
    ticks(1);
    expect_n("R3 long expiry", 1);

    set_sel(2'b10);
    ticks(2);
    restart();
    ticks(2);
    expect_n("R5 start+stop restarts", 0);
    ticks(1);
    expect_n("R5 expiry after restart", 1);

    restart();
    ticks(2);
    bus_start();
    ticks(1);
    expect_n("R6 start alone no restart", 1);
    bus_stop();
    ticks(2);
    expect_n("R5 late stop closes start", 0);
    ticks(1);
    expect_n("R5 expiry after late stop", 1);

    restart();
    ticks(2);
    @(negedge clk); scl = 1'b0; w3();
    sda = 1'b0; w3();
    sda = 1'b1; w3();
    sda = 1'b0; w3();
    scl = 1'b1; w3();
    sda = 1'b1; w3();
    ticks(1);
    expect_n("R7 lone stop and low-clock edges ignored", 1);

    restart();
    ticks(2);
    set_sel(2'b01);
    ticks(5);
    expect_n("R8 setting change restarts", 0);
    ticks(1);
    expect_n("R8 expiry in new period", 1);

    set_sel(2'b10);
    restart();
    ticks(2);
    @(negedge clk); hold = 1'b1;
    ticks(5);
    bus_start();
    expect_n("R9 no pulse during hold", 0);
    @(negedge clk); hold = 1'b0;
    w3();
    bus_stop();
    ticks(2);
    expect_n("R9 count cleared, start dropped", 0);
    ticks(1);
    expect_n("R9 expiry after hold", 1);

    restart();
    ticks(2);
    bus_start();
    @(negedge clk); scl = 1'b1; w3();
    sda = 1'b1;
    @(negedge clk);
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    expect_n("R10 restart beats final tick", 0);
    ticks(2);
    expect_n("R10 fresh period", 0);
    ticks(1);
    expect_n("R10 expiry after fresh period", 1);

    restart();
    ticks(2);
    set_sel(2'b11);
    ticks(20);
    expect_n("R4 off mid-count", 0);
    set_sel(2'b10);
    ticks(3);
    expect_n("R8 re-enable starts from zero", 1);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule